// File: doc/BRIEF.md
# Soft-Start Ramp Sequencer with Pre-bias

This block controls how the output of a buck converter is switched on and off. It works from a millisecond tick. After an enable command it checks the sampled output voltage for an existing pre-bias level, waits a configurable turn-on delay, and then ramps a digital voltage reference to the set point over a configurable rise time. After a disable command it waits a turn-off delay and ramps the reference back to zero over a fall time. When the load is light it skips the soft stop and turns off at once.

Beside the reference, the block produces a duty value for the synchronous-rectifier-enable PWM. This duty stays at zero while the reference is below three quarters of the set point. Above that level it is phased in, or phased out, by a fixed step on each tick. This keeps the lower switch from sinking current out of a pre-biased output. The set point, the four timing values, the sampled output and the light-load flag arrive as plain ports. The state code is brought out on `state_o` so that the surrounding logic can see the current phase.

Top module: `softstart_seq`

## Requirements
- R1: After reset, `state_o` is 0 (idle), `vref_o` is 0, `sre_duty_o` is 0 and `fault_o` is 0.
- R2: An enable in idle moves to state 1 (turn-on delay). `vref_o` holds the start level while `t_on_dly_i` ticks are counted, and then the state becomes 2 (rise).
- R3: In rise, after k ticks `vref_o` equals start + floor((set point − start)·k/T), where T is `t_rise_i`. After T ticks it equals the set point and the state becomes 3 (regulate). With T = 0, regulate is reached with `vref_o` at the set point and no tick is needed.
- R4: A sampled pre-bias below PB_MIN (300 codes) gives a start level of 0. A pre-bias equal to PB_MIN is used as the start level.
- R5: A pre-bias from PB_MIN to PB_MAX is the start level. If it lies above the set point, the reference ramps down: start − floor((start − set point)·k/T).
- R6: A pre-bias strictly above PB_MAX (3650 codes) leads to state 6 (fault) with `fault_o` = 1, `vref_o` = 0 and duty 0. A new enable is ignored there, and a disable returns to idle with `fault_o` = 0. A pre-bias equal to PB_MAX starts normally.
- R7: `sre_duty_o` is 0 whenever `vref_o` is below floor(3·set point/4). The set point used here is the one captured at enable.
- R8: In rise or regulate, each tick taken while `vref_o` is at or above the threshold raises the duty by SRE_STEP (16). The duty saturates at 2^DW − 1 (255).
- R9: A disable in regulate without light load moves to state 4 (turn-off delay). During the delay `vref_o` holds, and each tick lowers the duty by SRE_STEP, with a floor at 0. After `t_off_dly_i` ticks the state becomes 5 (fall), where `vref_o` falls to 0 exactly over `t_fall_i` ticks. The state then returns to idle.
- R10: A disable with `light_load_i` = 1 in states 1 to 3 gives idle, `vref_o` = 0 and duty 0 one clock later.
- R11: A disable during the turn-on delay or during rise moves to state 4. `vref_o` stays frozen at its current value until the fall starts.
- R12: An enable outside idle is ignored. An enable and a disable in the same cycle in idle leave the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse every millisecond |
| en_req_i | input | 1 | Turn-on command pulse |
| dis_req_i | input | 1 | Turn-off command pulse |
| light_load_i | input | 1 | Load current below the soft-stop limit |
| vset_i | input | VW | Configured output set point (codes) |
| vout_i | input | VW | Sampled output voltage (codes) |
| t_on_dly_i | input | TW | Turn-on delay in ticks |
| t_rise_i | input | TW | Rise time in ticks |
| t_off_dly_i | input | TW | Turn-off delay in ticks |
| t_fall_i | input | TW | Fall time in ticks |
| vref_o | output | VW | Digital voltage reference |
| sre_duty_o | output | DW | Synchronous-rectifier enable duty |
| state_o | output | 3 | Phase code: 0 idle, 1 on delay, 2 rise, 3 regulate, 4 off delay, 5 fall, 6 fault |
| fault_o | output | 1 | Pre-bias too high, start refused |

## Verification
The checks assume that `tick_i` is a single-cycle pulse, with at least one idle clock between ticks. They also assume that the set point and the four timing values do not change while a sequence is running, because the delay compares use the live timing ports. The bench drives each tick for one clock and then holds it low for three. It changes configuration only in idle, and it sends commands as one-cycle pulses. The duty checks depend on the threshold taken from the set point captured at enable. For that reason the bench computes its expected threshold from the value it applied at that moment.

// File: rtl/ss_pkg.sv
package ss_pkg;
   typedef enum logic [2:0] {
      SS_IDLE   = 3'd0,
      SS_ONDLY  = 3'd1,
      SS_RISE   = 3'd2,
      SS_REG    = 3'd3,
      SS_OFFDLY = 3'd4,
      SS_FALL   = 3'd5,
      SS_FAULT  = 3'd6
   } ss_state_e;
endpackage

// File: rtl/ss_ramp.sv
module ss_ramp #(
   parameter int VW = 12,
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld,
   input  logic [VW-1:0] from_i,
   input  logic [VW-1:0] to_i,
   input  logic [TW-1:0] dur_i,
   input  logic          adv,
   input  logic          tick,
   output logic [VW-1:0] val_o,
   output logic          done_o
);
   logic [VW-1:0] val_q, tgt_q, q_q;
   logic [TW-1:0] r_q, k_q, dur_q;
   logic [TW:0]   err_q;
   logic          dn_q;

   logic [VW-1:0] diff, dsafe, q_n, step;
   logic [TW-1:0] r_n;
   logic [TW:0]   err_sum, err_n;
   logic          carry;

   // quotient and remainder of span over duration, fed to an error accumulator
   always_comb begin
      diff    = (to_i >= from_i) ? (to_i - from_i) : (from_i - to_i);
      dsafe   = (dur_i == '0) ? VW'(1) : VW'(dur_i);
      q_n     = diff / dsafe;
      r_n     = TW'(diff % dsafe);
      err_sum = err_q + {1'b0, r_q};
      carry   = (err_sum >= {1'b0, dur_q});
      err_n   = carry ? (err_sum - {1'b0, dur_q}) : err_sum;
      step    = q_q + VW'(carry);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         val_q <= '0;
         tgt_q <= '0;
         q_q   <= '0;
         r_q   <= '0;
         k_q   <= '0;
         dur_q <= '0;
         err_q <= '0;
         dn_q  <= 1'b0;
      end else if (ld) begin
         val_q <= (dur_i == '0) ? to_i : from_i;
         tgt_q <= to_i;
         dn_q  <= (to_i < from_i);
         q_q   <= q_n;
         r_q   <= r_n;
         err_q <= '0;
         k_q   <= '0;
         dur_q <= dur_i;
      end else if (adv && tick && (k_q != dur_q)) begin
         k_q   <= k_q + 1'b1;
         err_q <= err_n;
         val_q <= dn_q ? (val_q - step) : (val_q + step);
      end
   end

   assign val_o  = val_q;
   assign done_o = (k_q == dur_q);

   // R3
   endpoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (k_q == dur_q) |-> (val_q == tgt_q));
   // R3
   ramp_up_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && tick && !ld && (k_q != dur_q) && !dn_q) |=> (val_q >= $past(val_q)));
   // R5
   ramp_dn_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && tick && !ld && (k_q != dur_q) && dn_q) |=> (val_q <= $past(val_q)));
endmodule

// File: rtl/ss_sre_slew.sv
module ss_sre_slew #(
   parameter int DW   = 8,
   parameter int STEP = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          up,
   input  logic          kill,
   input  logic          below,
   output logic [DW-1:0] duty_o
);
   localparam logic [DW-1:0] FULL   = {DW{1'b1}};
   localparam logic [DW-1:0] STEP_V = DW'(STEP);

   logic [DW-1:0] reg_q, up_v, dn_v;

   generate
      if (STEP >= (2 ** DW) - 1) begin : g_instant
         assign up_v = FULL;
         assign dn_v = '0;
      end else begin : g_slew
         assign up_v = (reg_q > (FULL - STEP_V)) ? FULL : (reg_q + STEP_V);
         assign dn_v = (reg_q < STEP_V) ? '0 : (reg_q - STEP_V);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)             reg_q <= '0;
      else if (kill || below) reg_q <= '0;
      else if (tick)          reg_q <= up ? up_v : dn_v;
   end

   assign duty_o = below ? '0 : reg_q;

   // R8
   slew_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!kill && !below) |=>
      (((reg_q >= $past(reg_q)) ? (reg_q - $past(reg_q)) : ($past(reg_q) - reg_q)) <= STEP_V));
endmodule

// File: rtl/ss_ctrl.sv
module ss_ctrl
   import ss_pkg::*;
#(
   parameter int VW     = 12,
   parameter int TW     = 8,
   parameter int PB_MIN = 300,
   parameter int PB_MAX = 3650
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          en_req,
   input  logic          dis_req,
   input  logic          light_load,
   input  logic [VW-1:0] vset,
   input  logic [VW-1:0] vout,
   input  logic [TW-1:0] t_on_dly,
   input  logic [TW-1:0] t_rise,
   input  logic [TW-1:0] t_off_dly,
   input  logic [TW-1:0] t_fall,
   input  logic [VW-1:0] ramp_val,
   input  logic          ramp_done,
   output ss_state_e     st_o,
   output logic          ld,
   output logic [VW-1:0] ld_from,
   output logic [VW-1:0] ld_to,
   output logic [TW-1:0] ld_dur,
   output logic          adv,
   output logic [VW-1:0] sp_o,
   output logic          sre_up,
   output logic          sre_kill,
   output logic          fault_o
);
   localparam logic [VW-1:0] PB_MIN_V = VW'(PB_MIN);
   localparam logic [VW-1:0] PB_MAX_V = VW'(PB_MAX);

   ss_state_e     st, st_n;
   logic [TW-1:0] cnt, cnt_n;
   logic [VW-1:0] start_q, start_n, sp_q, sp_n, pb_lvl;
   logic          stop, pb_bad;

   assign pb_bad = (vout > PB_MAX_V);
   assign pb_lvl = (vout < PB_MIN_V) ? '0 : vout;

   always_comb begin
      st_n    = st;
      cnt_n   = cnt;
      start_n = start_q;
      sp_n    = sp_q;
      ld      = 1'b0;
      ld_from = '0;
      ld_to   = '0;
      ld_dur  = '0;
      stop    = 1'b0;
      unique case (st)
         SS_IDLE: begin
            if (en_req && !dis_req) begin
               if (pb_bad) begin
                  st_n = SS_FAULT;
               end else begin
                  st_n    = SS_ONDLY;
                  cnt_n   = '0;
                  start_n = pb_lvl;
                  sp_n    = vset;
                  ld      = 1'b1;
                  ld_from = pb_lvl;
                  ld_to   = pb_lvl;
               end
            end
         end
         SS_ONDLY: begin
            if (dis_req) stop = 1'b1;
            else if (cnt == t_on_dly) begin
               st_n    = SS_RISE;
               ld      = 1'b1;
               ld_from = start_q;
               ld_to   = sp_q;
               ld_dur  = t_rise;
            end else if (tick) cnt_n = cnt + 1'b1;
         end
         SS_RISE: begin
            if (dis_req)        stop = 1'b1;
            else if (ramp_done) st_n = SS_REG;
         end
         SS_REG: begin
            if (dis_req) stop = 1'b1;
         end
         SS_OFFDLY: begin
            if (cnt == t_off_dly) begin
               st_n    = SS_FALL;
               ld      = 1'b1;
               ld_from = ramp_val;
               ld_to   = '0;
               ld_dur  = t_fall;
            end else if (tick) cnt_n = cnt + 1'b1;
         end
         SS_FALL: begin
            if (ramp_done) st_n = SS_IDLE;
         end
         SS_FAULT: begin
            if (dis_req) st_n = SS_IDLE;
         end
         default: st_n = SS_IDLE;
      endcase
      if (stop) begin
         if (light_load) begin
            st_n    = SS_IDLE;
            ld      = 1'b1;
            ld_from = '0;
            ld_to   = '0;
            ld_dur  = '0;
         end else begin
            st_n  = SS_OFFDLY;
            cnt_n = '0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= SS_IDLE;
         cnt     <= '0;
         start_q <= '0;
         sp_q    <= '0;
      end else begin
         st      <= st_n;
         cnt     <= cnt_n;
         start_q <= start_n;
         sp_q    <= sp_n;
      end
   end

   assign st_o     = st;
   assign sp_o     = sp_q;
   assign adv      = (st == SS_RISE) || (st == SS_FALL);
   assign sre_up   = (st == SS_RISE) || (st == SS_REG);
   assign sre_kill = (st_n == SS_IDLE) || (st_n == SS_ONDLY) || (st_n == SS_FAULT);
   assign fault_o  = (st == SS_FAULT);

   // R6
   fault_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_o) |-> ($past(vout) > PB_MAX_V));
   // R12
   en_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_req && !dis_req && (st == SS_REG)) |=> (st == SS_REG));
endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
   import ss_pkg::*;
#(
   parameter int VW       = 12,
   parameter int TW       = 8,
   parameter int DW       = 8,
   parameter int SRE_STEP = 16,
   parameter int PB_MIN   = 300,
   parameter int PB_MAX   = 3650
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_i,
   input  logic          en_req_i,
   input  logic          dis_req_i,
   input  logic          light_load_i,
   input  logic [VW-1:0] vset_i,
   input  logic [VW-1:0] vout_i,
   input  logic [TW-1:0] t_on_dly_i,
   input  logic [TW-1:0] t_rise_i,
   input  logic [TW-1:0] t_off_dly_i,
   input  logic [TW-1:0] t_fall_i,
   output logic [VW-1:0] vref_o,
   output logic [DW-1:0] sre_duty_o,
   output logic [2:0]    state_o,
   output logic          fault_o
);
   generate
      if (VW < TW) begin : g_bad_width
         $error("softstart_seq: VW must be at least TW");
      end
      if (PB_MIN >= PB_MAX || PB_MAX >= (2 ** VW)) begin : g_bad_pb
         $error("softstart_seq: need PB_MIN < PB_MAX < 2**VW");
      end
      if (SRE_STEP < 1 || SRE_STEP >= (2 ** DW)) begin : g_bad_step
         $error("softstart_seq: SRE_STEP out of range");
      end
   endgenerate

   ss_state_e     st;
   logic          ld, adv, ramp_done, sre_up, sre_kill, below;
   logic [VW-1:0] ld_from, ld_to, sp, thr;
   logic [TW-1:0] ld_dur;
   logic [VW+1:0] thr3;

   ss_ctrl #(.VW(VW), .TW(TW), .PB_MIN(PB_MIN), .PB_MAX(PB_MAX)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .tick(tick_i), .en_req(en_req_i),
      .dis_req(dis_req_i), .light_load(light_load_i), .vset(vset_i),
      .vout(vout_i), .t_on_dly(t_on_dly_i), .t_rise(t_rise_i),
      .t_off_dly(t_off_dly_i), .t_fall(t_fall_i), .ramp_val(vref_o),
      .ramp_done(ramp_done), .st_o(st), .ld(ld), .ld_from(ld_from),
      .ld_to(ld_to), .ld_dur(ld_dur), .adv(adv), .sp_o(sp),
      .sre_up(sre_up), .sre_kill(sre_kill), .fault_o(fault_o)
   );

   ss_ramp #(.VW(VW), .TW(TW)) u_ramp (
      .clk(clk), .rst_n(rst_n), .ld(ld), .from_i(ld_from), .to_i(ld_to),
      .dur_i(ld_dur), .adv(adv), .tick(tick_i), .val_o(vref_o),
      .done_o(ramp_done)
   );

   // three quarters of the captured set point, rounded down
   assign thr3  = {2'b00, sp} + {1'b0, sp, 1'b0};
   assign thr   = VW'(thr3 >> 2);
   assign below = (vref_o < thr);

   ss_sre_slew #(.DW(DW), .STEP(SRE_STEP)) u_sre (
      .clk(clk), .rst_n(rst_n), .tick(tick_i), .up(sre_up), .kill(sre_kill),
      .below(below), .duty_o(sre_duty_o)
   );

   assign state_o = st;

   // R3
   regulate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SS_REG) |-> (vref_o == sp));
   // R2
   ondly_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == SS_ONDLY) && ($past(st) == SS_ONDLY)) |-> $stable(vref_o));
   // R9
   offdly_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == SS_OFFDLY) && ($past(st) == SS_OFFDLY)) |-> $stable(vref_o));
   // R7
   sre_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == SS_IDLE) || (st == SS_ONDLY) || (st == SS_FAULT)) |-> (sre_duty_o == '0));
   // R10
   light_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dis_req_i && light_load_i && ((st == SS_ONDLY) || (st == SS_RISE) || (st == SS_REG)))
      |=> ((vref_o == '0) && (sre_duty_o == '0) && (st == SS_IDLE)));
endmodule

// File: tb/tb_softstart_seq.sv
`timescale 1ns/1ps
module tb_softstart_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0, en = 1'b0, dis = 1'b0, light = 1'b0;
   logic [11:0] vset = '0, vout = '0;
   logic [7:0]  t_on = '0, t_rise = '0, t_off = '0, t_fall = '0;
   logic [11:0] vref;
   logic [7:0]  duty;
   logic [2:0]  state;
   logic        fault;

   int n_chk = 0, n_fail = 0, cyc = 0;
   int thr = 0, mdl = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   softstart_seq dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .en_req_i(en), .dis_req_i(dis),
      .light_load_i(light), .vset_i(vset), .vout_i(vout), .t_on_dly_i(t_on),
      .t_rise_i(t_rise), .t_off_dly_i(t_off), .t_fall_i(t_fall),
      .vref_o(vref), .sre_duty_o(duty), .state_o(state), .fault_o(fault)
   );

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000 && !done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: run did not complete (actual %0d cycles, expected < 150000)", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic chk_eq(input string tag, input int act, input int exp);
      chk(act == exp, tag, act, exp);
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_tick();
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      settle(3);
   endtask

   // tick with duty model: a tick at/above threshold in rise/regulate adds 16,
   // in off delay/fall subtracts 16; below threshold the duty is zero
   task automatic mtick();
      int vb, sb;
      vb = vref; sb = state;
      do_tick();
      if (sb == 2 || sb == 3)      mdl = (vb >= thr) ? ((mdl + 16 > 255) ? 255 : mdl + 16) : 0;
      else if (sb == 4 || sb == 5) mdl = (vb >= thr) ? ((mdl < 16) ? 0 : mdl - 16) : 0;
      else                         mdl = 0;
   endtask

   function automatic int exp_duty();
      return (vref < thr) ? 0 : mdl;
   endfunction

   task automatic pulse_en();
      @(negedge clk) en = 1'b1;
      @(negedge clk) en = 1'b0;
      settle(2);
   endtask

   task automatic pulse_dis();
      @(negedge clk) dis = 1'b1;
      @(negedge clk) dis = 1'b0;
      settle(2);
   endtask

   task automatic dis_light();
      @(negedge clk) begin dis = 1'b1; light = 1'b1; end
      @(negedge clk) begin dis = 1'b0; light = 1'b0; end
      chk_eq("R10 state after light-load off", state, 0);
      chk_eq("R10 vref after light-load off", vref, 0);
      chk_eq("R10 duty after light-load off", duty, 0);
   endtask

   task automatic setup(input int vs, input int vo, input int ton, input int tr,
                        input int toff, input int tf);
      vset = 12'(vs); vout = 12'(vo);
      t_on = 8'(ton); t_rise = 8'(tr); t_off = 8'(toff); t_fall = 8'(tf);
      thr = (3 * vs) / 4; mdl = 0;
   endtask

   task automatic t_reset();
      chk_eq("R1 reset state", state, 0);
      chk_eq("R1 reset vref", vref, 0);
      chk_eq("R1 reset duty", duty, 0);
      chk_eq("R1 reset fault", fault, 0);
   endtask

   task automatic t_rise_zero_start();
      setup(1000, 200, 2, 7, 3, 5);
      pulse_en();
      chk_eq("R2 on-delay state", state, 1);
      chk_eq("R4 start level below min", vref, 0);
      do_tick();
      chk_eq("R2 still in on-delay after 1 tick", state, 1);
      do_tick();
      chk_eq("R2 rise after on-delay", state, 2);
      for (int k = 1; k <= 7; k++) begin
         mtick();
         chk_eq("R3 rise ramp value", vref, (1000 * k) / 7);
         chk_eq("R7 R8 duty during rise", duty, exp_duty());
      end
      chk_eq("R3 regulate after rise", state, 3);
      pulse_en();
      chk_eq("R12 enable ignored in regulate (state)", state, 3);
      chk_eq("R12 enable ignored in regulate (vref)", vref, 1000);
      for (int k = 0; k < 16; k++) mtick();
      chk_eq("R8 duty saturates", duty, 255);
      chk_eq("R8 model at saturation", mdl, 255);
   endtask

   task automatic t_soft_off();
      pulse_dis();
      chk_eq("R9 off-delay state", state, 4);
      for (int k = 1; k <= 3; k++) begin
         mtick();
         chk_eq("R9 duty slews down in off-delay", duty, 255 - 16 * k);
         chk_eq("R9 vref held in off-delay", vref, 1000);
      end
      chk_eq("R9 fall state", state, 5);
      for (int k = 1; k <= 5; k++) begin
         mtick();
         chk_eq("R9 fall ramp value", vref, 1000 - 200 * k);
         chk_eq("R7 duty during fall", duty, exp_duty());
      end
      chk_eq("R9 idle after fall", state, 0);
      chk_eq("R9 duty zero after fall", duty, 0);
   endtask

   task automatic t_prebias_down();
      setup(1200, 2000, 1, 4, 0, 0);
      pulse_en();
      chk_eq("R5 start at pre-bias", vref, 2000);
      do_tick();
      chk_eq("R2 rise after 1 tick delay", state, 2);
      for (int k = 1; k <= 4; k++) begin
         mtick();
         chk_eq("R5 downward ramp value", vref, 2000 - (800 * k) / 4);
         chk_eq("R8 duty rises above threshold", duty, 16 * k);
      end
      chk_eq("R5 regulate at set point", state, 3);
      dis_light();
   endtask

   task automatic t_fault();
      setup(1000, 3700, 0, 0, 0, 0);
      pulse_en();
      chk_eq("R6 fault state", state, 6);
      chk_eq("R6 fault flag", fault, 1);
      chk_eq("R6 vref in fault", vref, 0);
      chk_eq("R6 duty in fault", duty, 0);
      vout = 12'd0;
      pulse_en();
      chk_eq("R6 enable ignored in fault", state, 6);
      pulse_dis();
      chk_eq("R6 disable leaves fault", state, 0);
      chk_eq("R6 fault flag cleared", fault, 0);
   endtask

   task automatic t_bounds();
      setup(1000, 300, 5, 5, 0, 0);
      pulse_en();
      chk_eq("R4 pre-bias equal to min used", vref, 300);
      dis_light();
      setup(3000, 3650, 5, 5, 0, 0);
      pulse_en();
      chk_eq("R6 pre-bias equal to max starts", state, 1);
      chk_eq("R6 pre-bias equal to max level", vref, 3650);
      chk_eq("R6 no fault at max", fault, 0);
      dis_light();
      setup(800, 0, 0, 0, 0, 0);
      pulse_en();
      chk_eq("R3 zero rise time reaches regulate", state, 3);
      chk_eq("R3 zero rise time at set point", vref, 800);
      dis_light();
   endtask

   task automatic t_abort();
      setup(1000, 0, 0, 10, 2, 0);
      pulse_en();
      chk_eq("R11 in rise", state, 2);
      for (int k = 1; k <= 3; k++) do_tick();
      chk_eq("R3 partial rise", vref, 300);
      pulse_dis();
      chk_eq("R11 abort from rise to off-delay", state, 4);
      do_tick();
      chk_eq("R11 vref frozen", vref, 300);
      chk_eq("R11 still off-delay", state, 4);
      do_tick();
      chk_eq("R9 idle after zero-length fall", state, 0);
      chk_eq("R9 vref zero after zero-length fall", vref, 0);
      setup(1000, 500, 5, 4, 2, 0);
      pulse_en();
      do_tick();
      pulse_dis();
      chk_eq("R11 abort from on-delay", state, 4);
      chk_eq("R11 vref kept at start", vref, 500);
      do_tick();
      do_tick();
      chk_eq("R11 idle after abort", state, 0);
   endtask

   task automatic t_prio();
      setup(1000, 0, 0, 0, 0, 0);
      @(negedge clk) begin en = 1'b1; dis = 1'b1; end
      @(negedge clk) begin en = 1'b0; dis = 1'b0; end
      settle(2);
      chk_eq("R12 enable with disable stays idle", state, 0);
      chk_eq("R12 vref stays zero", vref, 0);
   endtask

   initial begin
      settle(4);
      t_reset();
      @(negedge clk) rst_n = 1'b1;
      settle(2);
      t_reset();
      t_rise_zero_start();
      t_soft_off();
      t_prebias_down();
      t_fault();
      t_bounds();
      t_abort();
      t_prio();
      done = 1;
      summary();
      $finish;
   end
endmodule